// File: doc/BRIEF.md
# Oversampling Serial Receiver with Multidrop Address Filter

This block recovers asynchronous serial characters from a single input line. A tick input, pulsing sixteen times per bit period, paces the sampling. Each character has one low start bit and 8 or 9 data bits, least significant first. In 8-bit mode an optional parity bit may follow. One or two high stop bits end the character. Each completed word goes into a small receive queue together with its own parity-error and framing-error flags. The queue head is always visible on the read port, and a one-cycle read strobe removes it.

Flow control comes from the queue level. The ready-to-send output drops once the queue holds three words, so a character already on the wire still has a free slot. If a word completes while the queue is full, that word is lost, a sticky overrun flag rises, and the receiver ignores the line until the flag is cleared. For multidrop buses, an address filter in 9-bit mode throws away every character whose ninth bit is clear. Software turns the filter off once its own address has arrived. A loopback select feeds the receiver from the local transmitter output instead of the pin.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset, rd_valid_o is 0, overrun_o is 0 and rts_o is 1.
- R2: A falling edge starts a character only if the line is still low at oversample 8 of the start bit. A shorter low pulse stores nothing.
- R3: Each data bit is the majority of oversamples 7, 8 and 9, and bits arrive least significant first. In 8-bit mode (nine_bit_i=0), rd_data_o[8] reads 0.
- R4: With nine_bit_i=1, nine data bits are received and stored in rd_data_o[8:0]. No parity bit is expected, and rd_perr_o is 0 whatever parity_mode_i holds.
- R5: In 8-bit mode, parity_mode_i selects the parity check: 0 or 3 means none, 1 means even, 2 means odd. A parity bit follows the eighth data bit. rd_perr_o marks a word whose data and parity bits together have the wrong count of ones.
- R6: If the first stop bit samples low, the word is still stored, with rd_ferr_o=1. A new start is recognised only after the line has been seen high again.
- R7: With two_stop_i=1, the receiver waits out a second stop bit before the word completes. Only the first stop bit sets rd_ferr_o, so a low second stop bit leaves it 0.
- R8: The queue holds 4 words and returns them in arrival order. rd_valid_o shows it is non-empty. A rd_i pulse removes the head, and rd_i while empty has no effect.
- R9: A word that completes while the queue is full is dropped and overrun_o is set. overrun_o stays set, and no character is received, until ovr_clr_i is pulsed.
- R10: With addr_detect_i=1 and nine_bit_i=1, a character whose ninth bit is 0 is discarded. It neither fills the queue nor sets overrun_o. A character whose ninth bit is 1 is stored.
- R11: rts_o is 1 while the queue holds fewer than 3 words and 0 otherwise.
- R12: With loopback_i=1, characters are taken from loop_tx_i and rx_i is ignored. With loopback_i=0, loop_tx_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversample enable, 16 pulses per bit period |
| rx_i | input | 1 | Serial input pin |
| loop_tx_i | input | 1 | Local transmitter output used in loopback |
| loopback_i | input | 1 | 1 selects loop_tx_i as the serial source |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| parity_mode_i | input | 2 | 0/3 none, 1 even, 2 odd (8-bit mode only) |
| two_stop_i | input | 1 | 1 expects two stop bits |
| addr_detect_i | input | 1 | 1 discards 9-bit characters whose ninth bit is 0 |
| rd_i | input | 1 | Pop the queue head |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 9 | Queue head data |
| rd_perr_o | output | 1 | Queue head parity error |
| rd_ferr_o | output | 1 | Queue head framing error |
| rd_valid_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| rts_o | output | 1 | Ready to send, 1 while queue level is below 3 |

## Verification
The bench sends a short low glitch. A receiver that trusts the first low sample would start on it and store a junk word. A second case has a low second stop bit under two-stop framing. A design that checks the wrong stop bit would flag a framing error on a good word, and one that rearms at once after a low stop bit would start on the tail of that bit. The overrun sequence first fills the queue, then sends more characters, then pops one slot free. A receiver that overwrote the queue, kept receiving or cleared the flag on a pop would show wrong head data or a stored word. The address-filter runs check that discarded characters never count toward overrun, and the loopback runs check that the unused source is ignored.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned WORD_W = 9;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_word_t;
endpackage

// File: rtl/uart_rx_in.sv
module uart_rx_in #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic loop_i,
  input  logic loop_sel_i,
  output logic line_o
);
  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;

  assign src = loop_sel_i ? loop_i : pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], src};
  end

  assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       halt_i,
  input  logic       nine_bit_i,
  input  logic [1:0] parity_mode_i,
  input  logic       two_stop_i,
  output logic       done_o,
  output rx_word_t   word_o
);
  localparam int unsigned CNT_W = $clog2(OVS + 1);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned MID   = OVS / 2;
  localparam logic [CNT_W-1:0] S_EARLY = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_MID   = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_LATE  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] S_LAST  = CNT_W'(OVS);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic [BIT_W-1:0]  bitn_q, last_bit;
  logic [WORD_W-1:0] shreg_q;
  logic [1:0]        smp_q;
  logic              ferr_q, armed_q, done_q, maj, has_par;
  rx_word_t          word_q, word_new;
  par_mode_e         pm;

  assign pm       = par_mode_e'(parity_mode_i);
  assign has_par  = !nine_bit_i && (pm == PAR_EVEN || pm == PAR_ODD);
  assign last_bit = (nine_bit_i || has_par) ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W - 2);
  assign idx      = (cnt_q == S_LAST) ? CNT_W'(1) : cnt_q + 1'b1;
  assign maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) | (smp_q[1] & line_i);

  always_comb begin
    word_new.data = nine_bit_i ? shreg_q : {1'b0, shreg_q[WORD_W-2:0]};
    word_new.perr = has_par && ((^shreg_q) ^ (pm == PAR_ODD));
    word_new.ferr = two_stop_i ? ferr_q : !maj;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      smp_q   <= '0;
      ferr_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (state_q != ST_IDLE) begin
          cnt_q <= idx;
          if (idx == S_EARLY) smp_q[0] <= line_i;
          if (idx == S_MID)   smp_q[1] <= line_i;
        end
        unique case (state_q)
          ST_IDLE: begin
            if (!armed_q) armed_q <= line_i;
            else if (!line_i && !halt_i) begin
              state_q <= ST_START;
              cnt_q   <= CNT_W'(1);
              shreg_q <= '0;
            end
          end
          ST_START: begin
            if (idx == S_MID && line_i) state_q <= ST_IDLE;   // glitch
            else if (idx == S_LAST) begin
              state_q <= ST_DATA;
              bitn_q  <= '0;
            end
          end
          ST_DATA: begin
            if (idx == S_LATE) shreg_q[bitn_q] <= maj;
            if (idx == S_LAST) begin
              if (bitn_q == last_bit) state_q <= ST_STOP1;
              else                    bitn_q  <= bitn_q + 1'b1;
            end
          end
          ST_STOP1: begin
            if (idx == S_LATE) begin
              if (two_stop_i) ferr_q <= !maj;
              else begin
                done_q  <= 1'b1;
                word_q  <= word_new;
                state_q <= ST_IDLE;
                armed_q <= line_i;
              end
            end
            if (idx == S_LAST && two_stop_i) state_q <= ST_STOP2;
          end
          ST_STOP2: begin
            if (idx == S_LATE) begin
              done_q  <= 1'b1;
              word_q  <= word_new;
              state_q <= ST_IDLE;
              armed_q <= line_i;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign word_o = word_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  rx_word_t                   wdata_i,
  input  logic                       pop_i,
  output rx_word_t                   head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned RTS_LEVEL   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic              loop_tx_i,
  input  logic              loopback_i,
  input  logic              nine_bit_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              two_stop_i,
  input  logic              addr_detect_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_valid_o,
  output logic              overrun_o,
  output logic              rts_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             line, f_done, f_msb, addr_skip, accept, push;
  logic             fifo_full, fifo_empty, ovr_q;
  logic [CNT_W-1:0] fifo_cnt;
  rx_word_t         f_word, head;

  uart_rx_in #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (rx_i),
    .loop_i     (loop_tx_i),
    .loop_sel_i (loopback_i),
    .line_o     (line)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick16_i),
    .line_i        (line),
    .halt_i        (ovr_q),
    .nine_bit_i    (nine_bit_i),
    .parity_mode_i (parity_mode_i),
    .two_stop_i    (two_stop_i),
    .done_o        (f_done),
    .word_o        (f_word)
  );

  assign f_msb     = f_word.data[WORD_W-1];
  assign addr_skip = addr_detect_i && nine_bit_i && !f_msb;
  assign accept    = f_done && !addr_skip;
  assign push      = accept && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovr_q <= 1'b0;
    else if (accept && fifo_full) ovr_q <= 1'b1;
    else if (ovr_clr_i)           ovr_q <= 1'b0;
  end

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (f_word),
    .pop_i   (rd_i),
    .head_o  (head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign rd_data_o  = head.data;
  assign rd_perr_o  = head.perr;
  assign rd_ferr_o  = head.ferr;
  assign rd_valid_o = !fifo_empty;
  assign overrun_o  = ovr_q;
  assign rts_o      = (fifo_cnt < CNT_W'(RTS_LEVEL));
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       rd_i,
  input logic                       ovr_clr_i,
  input logic                       addr_detect_i,
  input logic                       nine_bit_i,
  input logic                       rd_valid_o,
  input logic                       overrun_o,
  input logic                       rts_o,
  input logic                       f_done,
  input logic                       f_msb,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !ovr_clr_i |=> overrun_o);

  p_halt_no_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> !push);

  p_addr_discard_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_done && addr_detect_i && nine_bit_i && !f_msb && !rd_i && !ovr_clr_i
    |=> $stable(fifo_cnt) && $stable(overrun_o));

  p_rts_has_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_o |-> rd_valid_o);

  p_pop_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o && !push |=> !rd_valid_o);
endmodule

bind uart_rx_addr uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_i          (rd_i),
  .ovr_clr_i     (ovr_clr_i),
  .addr_detect_i (addr_detect_i),
  .nine_bit_i    (nine_bit_i),
  .rd_valid_o    (rd_valid_o),
  .overrun_o     (overrun_o),
  .rts_o         (rts_o),
  .f_done        (f_done),
  .f_msb         (f_msb),
  .push          (push),
  .fifo_cnt      (fifo_cnt)
);

// File: tb/uart_rx_addr_bench.sv
`timescale 1ns/1ps
module uart_rx_addr_bench;
  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

  typedef struct {
    logic [8:0] d;
    bit         pe;
    bit         fe;
  } exp_t;

  logic clk = 0, rst_n = 0, tick = 0;
  logic rx = 1, loop_tx = 1, cfg_loop = 0, cfg_nine = 0, cfg_two = 0, cfg_addr = 0;
  logic [1:0] cfg_par = 0;
  logic rd = 0, ovr_clr = 0;
  logic [8:0] rd_data;
  logic rd_perr, rd_ferr, rd_valid, overrun, rts;
  int   tcnt = 0;
  int   checks = 0, errors = 0;
  bit   ovr_m = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  uart_rx_addr u_uart_rx_addr (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx), .loop_tx_i(loop_tx),
    .loopback_i(cfg_loop), .nine_bit_i(cfg_nine), .parity_mode_i(cfg_par),
    .two_stop_i(cfg_two), .addr_detect_i(cfg_addr), .rd_i(rd), .ovr_clr_i(ovr_clr),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr),
    .rd_valid_o(rd_valid), .overrun_o(overrun), .rts_o(rts)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t expect_word(logic [8:0] d, bit nine, logic [1:0] par,
                                       bit bad_par, bit bad_s1);
    exp_t e;
    e.d  = nine ? d : {1'b0, d[7:0]};
    e.pe = !nine && (par == 2'd1 || par == 2'd2) && bad_par;
    e.fe = bad_s1;
    return e;
  endfunction

  function automatic bit par_bit(logic [7:0] d, logic [1:0] par, bit bad);
    return (^d) ^ (par == 2'd2) ^ bad;
  endfunction

  task automatic drive(input bit v, input bit via_loop);
    if (via_loop) loop_tx = v; else rx = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit via_loop = 0, input bit bad_par = 0,
                      input bit bad_s1 = 0, input bit bad_s2 = 0);
    exp_t e;
    drive(0, via_loop);
    for (int i = 0; i < 8; i++) drive(d[i], via_loop);
    if (cfg_nine) drive(d[8], via_loop);
    else if (cfg_par == 2'd1 || cfg_par == 2'd2) drive(par_bit(d[7:0], cfg_par, bad_par), via_loop);
    drive(!bad_s1, via_loop);
    if (cfg_two) drive(!bad_s2, via_loop);
    drive(1, via_loop);
    drive(1, via_loop);
    if (via_loop == cfg_loop && !ovr_m && !(cfg_addr && cfg_nine && !d[8])) begin
      e = expect_word(d, cfg_nine, cfg_par, bad_par, bad_s1);
      if (q.size() == 4) ovr_m = 1;
      else q.push_back(e);
    end
  endtask

  task automatic status(input string tag);
    chk(tag, "rd_valid", rd_valid, q.size() > 0);
    chk("R11", "rts", rts, q.size() < 3);
    chk("R9", "overrun", overrun, ovr_m);
  endtask

  task automatic pop(input string tag);
    exp_t e;
    chk(tag, "valid before pop", rd_valid, 1);
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(tag, "data", rd_data, e.d);
    chk(tag, "perr", rd_perr, e.pe);
    chk(tag, "ferr", rd_ferr, e.fe);
    rd = 1;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic pop_all(input string tag);
    while (q.size() > 0) pop(tag);
    chk(tag, "empty after drain", rd_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "rts", rts, 1);
    repeat (BIT_CLKS) @(negedge clk);

    // R3 8-bit, no parity
    send(9'h0A5); send(9'h03C); status("R3");
    pop_all("R3");

    // R4 nine bits, parity setting ignored
    cfg_nine = 1; cfg_par = 2'd1;
    send(9'h1A5); send(9'h05A); status("R4");
    pop_all("R4");
    cfg_par = 0;

    // R5 parity
    cfg_nine = 0;
    cfg_par = 2'd1; send(9'h0B7); send(9'h0B7, 0, 1);
    cfg_par = 2'd2; send(9'h0B7); send(9'h066, 0, 1);
    pop_all("R5");
    cfg_par = 2'd3; send(9'h081); pop_all("R5");
    cfg_par = 0;

    // R6 framing error, R7 second stop not checked
    send(9'h055, 0, 0, 1); send(9'h0AA); pop_all("R6");
    cfg_two = 1; send(9'h0C3, 0, 0, 0, 1); send(9'h03C); send(9'h0F0, 0, 0, 1);
    pop_all("R7");
    cfg_two = 0;

    // R2 glitch rejected
    rx = 0; repeat (16) @(negedge clk); rx = 1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R2", "glitch stored nothing", rd_valid, 0);
    send(9'h011); pop_all("R2");

    // R8 order, level, read while empty
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
    chk("R8", "pop on empty", rd_valid, 0);
    send(9'h001); send(9'h002); status("R11");
    send(9'h003); status("R11");
    send(9'h004); status("R8");
    pop_all("R8");

    // R9 overrun and halt
    for (int i = 0; i < 5; i++) send(9'(8'h10 + i));
    status("R9");
    send(9'h077); status("R9");
    pop("R9");
    send(9'h078); status("R9");
    ovr_clr = 1; @(negedge clk); ovr_clr = 0; ovr_m = 0;
    send(9'h079); status("R9");
    pop_all("R9");

    // R10 address detect
    cfg_nine = 1; cfg_addr = 1;
    send(9'h033); status("R10");
    send(9'h1C2); status("R10");
    cfg_addr = 0; send(9'h044);
    pop_all("R10");
    cfg_addr = 1;
    for (int i = 0; i < 4; i++) send(9'(9'h100 + i));
    send(9'h0EE); status("R10");
    pop_all("R10");
    cfg_addr = 0; cfg_nine = 0;

    // R12 loopback
    cfg_loop = 1; send(9'h0D2, 1); status("R12");
    send(9'h0D3, 0); status("R12");
    pop_all("R12");
    cfg_loop = 0; send(9'h0D4, 1); status("R12");
    send(9'h0D5, 0); pop_all("R12");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [8:0] d;
      bit bp, b1, b2;
      d = 9'($urandom);
      cfg_nine = 1'($urandom % 2);
      cfg_par = 2'($urandom % 4);
      cfg_two = 1'($urandom % 2);
      bp = ($urandom % 4) == 0;
      b1 = ($urandom % 5) == 0;
      b2 = ($urandom % 3) == 0;
      send(d, 0, bp, b1, b2);
      status("R3");
      if (q.size() >= 3 || ($urandom % 3) == 0) pop_all("R5");
    end
    pop_all("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule